// File: doc/BRIEF.md
# Strobe-Driven Slave FIFO Write Port

This block is the write side of a peripheral FIFO that an external master fills. The master presents a data word and a write strobe. The block stores each accepted word in an internal FIFO of `DEPTH` entries. It reports the FIFO condition back on active-low empty and full flags. The internal side drains the FIFO through a pop strobe and receives registered read data with a one-cycle valid pulse.

Software picks the acceptance scheme at run time through a small register port. In clocked mode, a word is taken on every rising clock edge while the strobe is held at its active level. In release-edge mode, the strobe is resynchronised into the clock domain, and exactly one word is taken each time the strobe goes from active to inactive. A polarity register sets the strobe's active level. A further mode bit chooses whether the block drives a divided clock out on the interface clock pin or leaves that pin as an input.

The write side has no stall signal; back-pressure is advisory. The master must stop strobing while `full_n_o` is low. Any word offered while the FIFO is full is dropped and recorded in a sticky overflow bit. The read side cannot stall either. The consumer must take `pop_data_o` in the cycle `pop_vld_o` is high. A pop issued while the FIFO is empty is ignored.

Top module: `slave_fifo_wr`

## Requirements
- R1: After reset, `empty_n_o`=0, `full_n_o`=1, `ovf_o`=0, `pop_vld_o`=0, `ifc_clk_oe_o`=0 and `ifc_clk_o`=0. Clocked mode is selected and the strobe is active-low.
- R2: With mode-register bit 3 = 0 (clocked mode), a word from `wr_data_i` is stored at every rising edge of `clk` where the strobe is at its active level. Holding the strobe active for k edges stores k words.
- R3: With mode-register bit 3 = 1 (release-edge mode), exactly one word is stored per active-to-inactive strobe transition, however long the strobe was held active. The word stored is the data present at the first edge that samples the inactive level. The word is pushed at the third rising edge after the strobe goes inactive.
- R4: Polarity-register bit 0 = 0 makes the strobe active-low, and 1 makes it active-high.
- R5: A polarity-register write clears the resynchronised strobe history and blocks any clocked-mode store in that cycle. A master that moves its strobe to the new inactive level in the same cycle as the write causes no store in either mode.
- R6: Words leave the FIFO in the order they were stored. A pop on a non-empty FIFO gives `pop_vld_o`=1 with the head word on `pop_data_o` after the next rising edge.
- R7: `empty_n_o` is low exactly when 0 words are held, and `full_n_o` is low exactly when `DEPTH` words are held. Both flags reflect a push or pop from the rising edge at which it takes place.
- R8: A store attempted while the FIFO is full is discarded and sets `ovf_o`, which stays set. A register write with `cfg_sel_i`=2 clears it.
- R9: A pop while the FIFO is empty produces no `pop_vld_o` and changes no flag.
- R10: A push and a pop in the same cycle, on a FIFO that is neither empty nor full, both take effect and leave the fill level unchanged.
- R11: Mode-register bit 7 = 1 raises `ifc_clk_oe_o` and makes `ifc_clk_o` toggle on every clock edge. With bit 7 = 0, `ifc_clk_oe_o` is low and `ifc_clk_o` is low from the second edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core and interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Register write enable |
| cfg_sel_i | input | 2 | Register select: 0 mode, 1 polarity, 2 overflow clear |
| cfg_wdata_i | input | 8 | Register write data |
| wr_strb_i | input | 1 | External write strobe, polarity programmable |
| wr_data_i | input | DW | External write data bus |
| pop_i | input | 1 | Internal-side pop request |
| pop_data_o | output | DW | Registered head word |
| pop_vld_o | output | 1 | One-cycle pulse marking `pop_data_o` valid |
| empty_n_o | output | 1 | Low while the FIFO is empty |
| full_n_o | output | 1 | Low while the FIFO is full |
| ovf_o | output | 1 | Sticky overflow indication |
| ifc_clk_o | output | 1 | Internally generated interface clock |
| ifc_clk_oe_o | output | 1 | Drive enable for the interface clock pin |

## Verification
Clocked bursts of varying length, under each strobe polarity, separate a per-edge store from a per-transition store. Release-edge writes with long active holds show that a held strobe still yields one word. Polarity flips made while the strobe moves to its new idle level show whether the history flush suppresses a spurious store. Filling to `DEPTH` and one beyond, draining past empty, and random mixes of simultaneous push and pop expose off-by-one errors in the flags, the drop-on-full path and ordering against a reference queue.

// File: rtl/slvwr_pkg.sv
package slvwr_pkg;
  localparam logic [1:0] SEL_MODE   = 2'd0;
  localparam logic [1:0] SEL_POL    = 2'd1;
  localparam logic [1:0] SEL_OVFCLR = 2'd2;

  localparam int MODE_ASYNC_BIT  = 3;
  localparam int MODE_CLKINT_BIT = 7;
  localparam int POL_STRB_BIT    = 0;
endpackage

// File: rtl/slvwr_cfg.sv
module slvwr_cfg
  import slvwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr_i,
  input  logic [1:0] cfg_sel_i,
  input  logic [7:0] cfg_wdata_i,
  output logic       async_o,
  output logic       clk_int_o,
  output logic       act_high_o,
  output logic       pol_wr_o,
  output logic       ovf_clr_o,
  output logic       ifc_clk_o
);
  logic wr_mode;
  logic async_q, clk_int_q, act_high_q, gen_clk_q;
  logic unused_cfg_bits;

  assign wr_mode   = cfg_wr_i && (cfg_sel_i == SEL_MODE);
  assign pol_wr_o  = cfg_wr_i && (cfg_sel_i == SEL_POL);
  assign ovf_clr_o = cfg_wr_i && (cfg_sel_i == SEL_OVFCLR);
  assign unused_cfg_bits = ^{cfg_wdata_i[6:4], cfg_wdata_i[2:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      async_q    <= 1'b0;
      clk_int_q  <= 1'b0;
      act_high_q <= 1'b0;
    end else begin
      if (wr_mode) begin
        async_q   <= cfg_wdata_i[MODE_ASYNC_BIT];
        clk_int_q <= cfg_wdata_i[MODE_CLKINT_BIT];
      end
      if (pol_wr_o) act_high_q <= cfg_wdata_i[POL_STRB_BIT];
    end
  end

  // divided clock, parked low when the pin is an input
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         gen_clk_q <= 1'b0;
    else if (clk_int_q) gen_clk_q <= ~gen_clk_q;
    else                gen_clk_q <= 1'b0;
  end

  assign async_o    = async_q;
  assign clk_int_o  = clk_int_q;
  assign act_high_o = act_high_q;
  assign ifc_clk_o  = gen_clk_q;

  // R11
  clk_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_int_o |=> !ifc_clk_o);
  // R11
  clk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ifc_clk_o |=> !ifc_clk_o);
endmodule

// File: rtl/slvwr_strobe.sv
module slvwr_strobe #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          async_i,
  input  logic          act_high_i,
  input  logic          pol_wr_i,
  input  logic          strb_i,
  input  logic [DW-1:0] data_i,
  output logic          push_o,
  output logic [DW-1:0] push_data_o
);
  localparam int HIST = SYNC_STAGES + 1;

  logic                           act_now;
  logic [HIST-1:0]                act_q;
  logic [SYNC_STAGES-1:0][DW-1:0] dat_q;
  logic                           release_evt;

  // normalise to "strobe asserted" before crossing
  assign act_now = act_high_i ? strb_i : ~strb_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        act_q <= '0;
    else if (pol_wr_i) act_q <= '0;
    else               act_q <= {act_q[HIST-2:0], act_now};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
    end else begin
      dat_q[0] <= data_i;
      for (int k = 1; k < SYNC_STAGES; k++) dat_q[k] <= dat_q[k-1];
    end
  end

  assign release_evt = act_q[HIST-1] & ~act_q[HIST-2];

  assign push_o      = async_i ? release_evt : (act_now & ~pol_wr_i);
  assign push_data_o = async_i ? dat_q[SYNC_STAGES-1] : data_i;

  // R3
  rel_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (async_i && push_o) |=> !(async_i && push_o));
  // R5
  pol_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pol_wr_i |=> (act_q == '0));
endmodule

// File: rtl/slvwr_fifo.sv
module slvwr_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  input  logic          ovf_clr_i,
  output logic [DW-1:0] pop_data_o,
  output logic          pop_vld_o,
  output logic          empty_n_o,
  output logic          full_n_o,
  output logic          ovf_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          full, empty, do_push, do_pop;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push_i & ~full;
  assign do_pop  = pop_i & ~empty;

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wptr_q] <= push_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q     <= '0;
      rptr_q     <= '0;
      cnt_q      <= '0;
      pop_vld_o  <= 1'b0;
      pop_data_o <= '0;
      ovf_o      <= 1'b0;
    end else begin
      if (do_push) wptr_q <= ptr_next(wptr_q);
      if (do_pop) begin
        rptr_q     <= ptr_next(rptr_q);
        pop_data_o <= mem_q[rptr_q];
      end
      pop_vld_o <= do_pop;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      // a fresh overflow outranks a clear in the same cycle
      if (push_i && full) ovf_o <= 1'b1;
      else if (ovf_clr_i) ovf_o <= 1'b0;
    end
  end

  assign empty_n_o = ~empty;
  assign full_n_o  = ~full;

  // R7
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty_n_o || full_n_o);
  // R7
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R8
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !full_n_o) |=> ovf_o);
  // R8
  ovf_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !full_n_o && !pop_i) |=> !full_n_o);
  // R9
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !empty_n_o && !push_i) |=> (!pop_vld_o && !empty_n_o));
  // R10
  pushpop_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && full_n_o && empty_n_o) |=> $stable(cnt_q));
endmodule

// File: rtl/slave_fifo_wr.sv
module slave_fifo_wr #(
  parameter int DW          = 8,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr_i,
  input  logic [1:0]    cfg_sel_i,
  input  logic [7:0]    cfg_wdata_i,
  input  logic          wr_strb_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] pop_data_o,
  output logic          pop_vld_o,
  output logic          empty_n_o,
  output logic          full_n_o,
  output logic          ovf_o,
  output logic          ifc_clk_o,
  output logic          ifc_clk_oe_o
);
  logic          async_m, clk_int, act_high, pol_wr, ovf_clr;
  logic          push;
  logic [DW-1:0] push_data;

  slvwr_cfg u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_i    (cfg_wr_i),
    .cfg_sel_i   (cfg_sel_i),
    .cfg_wdata_i (cfg_wdata_i),
    .async_o     (async_m),
    .clk_int_o   (clk_int),
    .act_high_o  (act_high),
    .pol_wr_o    (pol_wr),
    .ovf_clr_o   (ovf_clr),
    .ifc_clk_o   (ifc_clk_o)
  );

  slvwr_strobe #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_strobe (
    .clk         (clk),
    .rst_n       (rst_n),
    .async_i     (async_m),
    .act_high_i  (act_high),
    .pol_wr_i    (pol_wr),
    .strb_i      (wr_strb_i),
    .data_i      (wr_data_i),
    .push_o      (push),
    .push_data_o (push_data)
  );

  slvwr_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push),
    .push_data_i (push_data),
    .pop_i       (pop_i),
    .ovf_clr_i   (ovf_clr),
    .pop_data_o  (pop_data_o),
    .pop_vld_o   (pop_vld_o),
    .empty_n_o   (empty_n_o),
    .full_n_o    (full_n_o),
    .ovf_o       (ovf_o)
  );

  assign ifc_clk_oe_o = clk_int;
endmodule

// File: tb/slave_fifo_wr_test.sv
`timescale 1ns/1ps
module slave_fifo_wr_test;
  localparam int DW    = 8;
  localparam int DEPTH = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [1:0]    cfg_sel = 2'd0;
  logic [7:0]    cfg_wdata = 8'd0;
  logic          wr_strb = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic          pop = 1'b0;
  logic [DW-1:0] pop_data;
  logic          pop_vld, empty_n, full_n, ovf, ifc_clk, ifc_clk_oe;

  int total = 0;
  int bad = 0;
  logic [DW-1:0] q[$];
  bit ovf_m = 1'b0;
  bit pol_m = 1'b0;

  always #2.5 clk = ~clk;

  slave_fifo_wr #(.DW(DW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .wr_strb_i(wr_strb), .wr_data_i(wr_data),
    .pop_i(pop), .pop_data_o(pop_data), .pop_vld_o(pop_vld),
    .empty_n_o(empty_n), .full_n_o(full_n), .ovf_o(ovf),
    .ifc_clk_o(ifc_clk), .ifc_clk_oe_o(ifc_clk_oe)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic bit idle_lvl();
    return pol_m ? 1'b0 : 1'b1;
  endfunction

  task automatic check_flags(input string tag);
    chk(empty_n == (q.size() != 0), {tag, " R7 empty_n"}, empty_n, q.size() != 0);
    chk(full_n == (q.size() != DEPTH), {tag, " R7 full_n"}, full_n, q.size() != DEPTH);
    chk(ovf == ovf_m, {tag, " R8 ovf"}, ovf, ovf_m);
  endtask

  // all tasks start and end just after a falling edge
  task automatic cfg_write(input logic [1:0] s, input logic [7:0] d);
    cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic set_pol(input bit p);
    cfg_wr = 1'b1; cfg_sel = 2'd1; cfg_wdata = {7'd0, p};
    pol_m = p;
    wr_strb = idle_lvl();
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic clear_ovf();
    cfg_write(2'd2, 8'd0);
    ovf_m = 1'b0;
    chk(ovf == 1'b0, "R8 overflow clear", ovf, 0);
  endtask

  // one clock edge: clocked-mode push and/or pop
  task automatic step(input bit push, input logic [DW-1:0] d, input bit pp, input string tag);
    bit exp_vld;
    logic [DW-1:0] exp_d;
    bit full_pre;
    exp_vld = 1'b0;
    exp_d = '0;
    full_pre = (q.size() == DEPTH);
    wr_strb = pol_m ? push : ~push;
    wr_data = d;
    pop = pp;
    if (pp && q.size() > 0) begin
      exp_d = q.pop_front();
      exp_vld = 1'b1;
    end
    if (push) begin
      if (full_pre) ovf_m = 1'b1;
      else q.push_back(d);
    end
    @(negedge clk);
    wr_strb = idle_lvl();
    pop = 1'b0;
    chk(pop_vld == exp_vld, {tag, " R6 R9 pop valid"}, pop_vld, exp_vld);
    if (exp_vld) chk(pop_data == exp_d, {tag, " R6 pop order"}, pop_data, exp_d);
    check_flags(tag);
  endtask

  // release-edge mode write with a long active hold
  task automatic async_write(input logic [DW-1:0] d, input int hold, input string tag);
    wr_strb = ~idle_lvl();
    wr_data = d;
    repeat (hold) @(negedge clk);
    wr_strb = idle_lvl();
    repeat (3) @(negedge clk);
    if (q.size() == DEPTH) ovf_m = 1'b1;
    else q.push_back(d);
    check_flags({tag, " R3"});
    repeat (2) @(negedge clk);
    check_flags({tag, " R3 single"});
  endtask

  task automatic drain(input string tag);
    while (q.size() > 0) step(1'b0, '0, 1'b1, tag);
    step(1'b0, '0, 1'b1, {tag, " R9 empty pop"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic a, b;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(empty_n == 1'b0, "R1 empty_n", empty_n, 0);
    chk(full_n == 1'b1, "R1 full_n", full_n, 1);
    chk(ovf == 1'b0, "R1 ovf", ovf, 0);
    chk(pop_vld == 1'b0, "R1 pop_vld", pop_vld, 0);
    chk(ifc_clk_oe == 1'b0, "R1 oe", ifc_clk_oe, 0);
    chk(ifc_clk == 1'b0, "R1 clk out", ifc_clk, 0);

    // R11 clock source
    cfg_write(2'd0, 8'h80);
    @(negedge clk); a = ifc_clk;
    @(negedge clk); b = ifc_clk;
    chk(a != b, "R11 clock toggles", b, !a);
    chk(ifc_clk_oe == 1'b1, "R11 oe high", ifc_clk_oe, 1);
    cfg_write(2'd0, 8'h00);
    @(negedge clk);
    chk(ifc_clk_oe == 1'b0, "R11 oe low", ifc_clk_oe, 0);
    chk(ifc_clk == 1'b0, "R11 clock parked", ifc_clk, 0);
    @(negedge clk);
    chk(ifc_clk == 1'b0, "R11 clock stays parked", ifc_clk, 0);

    // R2 R4 clocked burst, active-low strobe
    for (int i = 0; i < 5; i++) step(1'b1, 8'(8'h10 + i), 1'b0, "R2 burst low");
    drain("R6 drain");

    // R7 R8 fill to full and beyond
    for (int i = 0; i < DEPTH; i++) step(1'b1, 8'($urandom), 1'b0, "R7 fill");
    chk(full_n == 1'b0, "R7 full at DEPTH", full_n, 0);
    step(1'b1, 8'hEE, 1'b0, "R8 push on full");
    step(1'b1, 8'hEF, 1'b1, "R8 push+pop on full");
    clear_ovf();
    // R10 simultaneous push and pop
    for (int i = 0; i < 4; i++) step(1'b1, 8'($urandom), 1'b1, "R10 push+pop");
    drain("R6 drain full");

    // R5 R4 switch to active-high in clocked mode
    set_pol(1'b1);
    step(1'b0, '0, 1'b1, "R5 no spurious store");
    for (int i = 0; i < 3; i++) step(1'b1, 8'(8'hA0 + i), 1'b0, "R2 R4 burst high");
    drain("R4 drain high");

    // R3 release-edge mode, active-high then active-low
    cfg_write(2'd0, 8'h08);
    async_write(8'h5A, 6, "R3 high");
    async_write(8'hC3, 2, "R3 high short");
    set_pol(1'b0);
    repeat (4) @(negedge clk);
    check_flags("R5 async flip");
    async_write(8'h3C, 5, "R3 low");
    drain("R3 drain");
    chk(q.size() == 0, "R3 model empty", q.size(), 0);

    // random clocked-mode traffic
    cfg_write(2'd0, 8'h00);
    for (int i = 0; i < 500; i++) begin
      int r;
      r = $urandom % 100;
      if (r < 3) set_pol(~pol_m);
      else if (r < 5) clear_ovf();
      else step(($urandom % 100) < 60, 8'($urandom), ($urandom % 2) == 1, "R2 R10 random");
    end
    drain("R6 random drain");

    // random release-edge traffic
    cfg_write(2'd0, 8'h08);
    for (int i = 0; i < 40; i++) begin
      int r;
      r = $urandom % 10;
      if (r < 1) begin set_pol(~pol_m); repeat (4) @(negedge clk); check_flags("R5 random flip"); end
      else if (r < 3) step(1'b0, '0, 1'b1, "R6 async pop");
      else async_write(8'($urandom), 1 + ($urandom % 5), "R3 random");
    end
    drain("R3 final drain");
    clear_ovf();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule